// File: doc/BRIEF.md
# Directed-Rounding Floating-Point Adder

This block adds or subtracts two binary floating-point numbers in a compact format (half precision by default: 1 sign bit, 5 exponent bits, 10 fraction bits). The rounding direction of each directed operation comes from its opcode, so software building interval bounds can issue a round-up add straight after a round-down add with no mode change in between. Every operation is accepted on a clock edge and its result is registered, so results appear one cycle after the strobe.

Two legacy opcodes take their rounding from a mode register instead. That register is written beforehand and stays in force until it is written again. One setting of this register makes each legacy operation pick its rounding from a 16-bit on-chip pseudo-random generator. A separate interval strobe runs two lanes together. It adds two lower bounds with rounding toward negative infinity and two upper bounds with rounding toward positive infinity, both in the same cycle.

Top module: `dirround_fadd`

## Requirements
- R1: Opcode encoding is 000 add-legacy, 001 sub-legacy, 010 add-up, 011 add-down, 100 add-toward-zero, 101 sub-up, 110 sub-down, 111 sub-toward-zero. An operation strobed with op_valid at a clock edge drives out_valid high and its result onto out_lo after that edge. With no strobe at an edge, out_valid is low after it.
- R2: Round to nearest resolves an exact halfway case to the neighbour with an even last fraction bit. A case above halfway goes to the larger-magnitude neighbour.
- R3: Legacy opcodes round by the mode register, which cfg_we loads from cfg_mode: 0 nearest, 1 up, 2 down, 3 toward zero, 4 to 7 random. The mode persists across operations. A write in the same cycle as an operation takes effect from the next operation.
- R4: In random mode each legacy operation rounds by the two low bits of a 16-bit generator (same code as R3), seeded 16'hACE1. The generator then steps to (s>>1) XOR (s[0] ? 16'hB400 : 0). It steps only on an accepted legacy operation in random mode. Directed opcodes ignore random mode.
- R5: ivl_valid gives out_lo = ivl_lo_a+ivl_lo_b rounded down and out_hi = ivl_hi_a+ivl_hi_b rounded up, with out_ivl high. It takes priority over op_valid, and a legacy operation displaced this way does not step the generator. For non-interval results, out_hi and the lane-1 flags are zero.
- R6: A finite result too large in magnitude sets overflow and inexact. A positive result becomes +infinity under up or nearest rounding and the largest finite value under down or toward-zero. A negative result mirrors this.
- R7: An exact zero from operands of opposite effective sign is -0 under down rounding and +0 otherwise. Zeros of equal sign keep that sign.
- R8: Subnormal operands and results are exact where representable and rounded with the full sticky information, including a carry from the subnormal range into the smallest normal.
- R9: A NaN operand, or infinities of opposite effective sign, give the quiet NaN 16'h7E00 with no flags. Otherwise an infinite operand gives an infinity of its effective sign with no flags.
- R10: The inexact flag (bit 0 lane 0, bit 1 lane 1) is set exactly when the rounded result differs from the exact sum.
- R11: After reset out_valid, out_ivl, out_lo, out_hi and all flags are zero, the mode is nearest and the generator holds its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the mode register |
| cfg_mode | input | 3 | New mode register value |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation and rounding select |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (subtrahend for sub) |
| ivl_valid | input | 1 | Interval add strobe |
| ivl_lo_a | input | 16 | First lower bound |
| ivl_lo_b | input | 16 | Second lower bound |
| ivl_hi_a | input | 16 | First upper bound |
| ivl_hi_b | input | 16 | Second upper bound |
| out_valid | output | 1 | Result valid |
| out_ivl | output | 1 | Result is an interval |
| out_lo | output | 16 | Lane 0 result (lower bound for intervals) |
| out_hi | output | 16 | Lane 1 result (upper bound) |
| out_inexact | output | 2 | Inexact flag per lane |
| out_overflow | output | 2 | Overflow flag per lane |

## Verification
The bench builds the block with its default parameters: a 5-bit exponent and a 10-bit fraction, so every operand is a 16-bit value worked out by hand. That width makes the largest finite value small enough that a single upward rounding of max plus one overflows. It also makes halfway cases one or two positions below the unit of 1.0 easy to write down. The subnormal range starts at 16'h0001, so the jump from subnormal to normal and the far-alignment sticky path both fall within short directed vectors.

// File: rtl/dirround_fadd_pkg.sv
// Shared types for the directed-rounding adder.
// Assumes nothing beyond a 3-bit opcode and 2-bit rounding code.
package dirround_fadd_pkg;

    typedef enum logic [1:0] {
        RND_NE = 2'd0,
        RND_UP = 2'd1,
        RND_DN = 2'd2,
        RND_TZ = 2'd3
    } rnd_e;

    localparam logic [2:0] OP_ADD_LEG = 3'b000;
    localparam logic [2:0] OP_SUB_LEG = 3'b001;
    localparam logic [2:0] OP_ADD_UP  = 3'b010;
    localparam logic [2:0] OP_ADD_DN  = 3'b011;
    localparam logic [2:0] OP_ADD_TZ  = 3'b100;
    localparam logic [2:0] OP_SUB_UP  = 3'b101;
    localparam logic [2:0] OP_SUB_DN  = 3'b110;
    localparam logic [2:0] OP_SUB_TZ  = 3'b111;

endpackage

// File: rtl/dirround_fadd_lfsr.sv
// Galois shift-register generator for random legacy rounding.
// Steps once per cycle with step high; exposes only the two low bits.
module dirround_fadd_lfsr #(
    parameter int            LW   = 16,
    parameter logic [LW-1:0] TAPS = 16'hB400,
    parameter logic [LW-1:0] SEED = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [1:0] pick
);
    logic [LW-1:0] state_q;

    // Hold or advance the generator state
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (step)
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    end

    assign pick = state_q[1:0];
endmodule

// File: rtl/dirround_fadd_ctl.sv
// Opcode decode and mode register. Chooses per-lane rounding and the
// add/subtract sense for lane 0; interval strobe overrides the opcode.
module dirround_fadd_ctl
    import dirround_fadd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic       op_valid,
    input  logic [2:0] op_code,
    input  logic       ivl_valid,
    input  logic [1:0] rnd_bits,
    output logic       l0_sub,
    output rnd_e       l0_rm,
    output logic       lfsr_step,
    output logic       rand_mode,
    output logic       fire
);
    logic [2:0] mode_q;
    logic       legacy;

    // Mode register written by software-side configuration
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 3'd0;
        else if (cfg_we)
            mode_q <= cfg_mode;
    end

    assign rand_mode = mode_q[2];
    assign legacy    = (op_code[2:1] == 2'b00);
    assign lfsr_step = op_valid && !ivl_valid && legacy && rand_mode;
    assign fire      = op_valid || ivl_valid;

    // Decode subtract sense and rounding for lane 0
    always_comb begin
        l0_sub = 1'b0;
        l0_rm  = RND_NE;
        if (ivl_valid) begin
            l0_rm = RND_DN;
        end else begin
            case (op_code)
                OP_ADD_LEG, OP_SUB_LEG:
                    l0_rm = rand_mode ? rnd_e'(rnd_bits) : rnd_e'(mode_q[1:0]);
                OP_ADD_UP, OP_SUB_UP: l0_rm = RND_UP;
                OP_ADD_DN, OP_SUB_DN: l0_rm = RND_DN;
                default:              l0_rm = RND_TZ;
            endcase
            l0_sub = (op_code == OP_SUB_LEG) || (op_code == OP_SUB_UP) ||
                     (op_code == OP_SUB_DN)  || (op_code == OP_SUB_TZ);
        end
    end
endmodule

// File: rtl/dirround_fadd_core.sv
// Combinational floating-point add/subtract with a selectable rounding.
// Handles subnormals, infinities and NaN; three extra bits below the
// fraction (guard, round, sticky) carry the discarded part of the sum.
module dirround_fadd_core
    import dirround_fadd_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  logic                 sub,
    input  rnd_e                 rm,
    output logic [EXP_W+MAN_W:0] y,
    output logic                 inexact,
    output logic                 overflow
);
    localparam int FW   = 1 + EXP_W + MAN_W;
    localparam int SW   = MAN_W + 1;
    localparam int W    = MAN_W + 4;
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam logic [FW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic             a_sgn, b_sgn, a_nan, b_nan, a_inf, b_inf, swap;
    logic [FW-2:0]    x_mag, y_mag;
    logic             x_sgn, y_sgn, eff_sub, hidden, lsb, grd, stk, inc, to_inf;
    logic [SW-1:0]    x_sig, y_sig;
    logic [W-1:0]     big, small_full, algn, nrm;
    logic [W:0]       sum;
    logic [SW:0]      mant_r;
    logic             nstk, res_sgn;
    int               ee_x, ee_y, diff, lz, shamt, nexp, efield;

    // Align, add, normalise, round and pack one result
    always_comb begin
        a_sgn = a[FW-1];
        b_sgn = b[FW-1] ^ sub;
        a_nan = (&a[FW-2:MAN_W]) && (|a[MAN_W-1:0]);
        b_nan = (&b[FW-2:MAN_W]) && (|b[MAN_W-1:0]);
        a_inf = (&a[FW-2:MAN_W]) && !(|a[MAN_W-1:0]);
        b_inf = (&b[FW-2:MAN_W]) && !(|b[MAN_W-1:0]);
        swap  = (b[FW-2:0] > a[FW-2:0]);
        x_mag = swap ? b[FW-2:0] : a[FW-2:0];
        y_mag = swap ? a[FW-2:0] : b[FW-2:0];
        x_sgn = swap ? b_sgn : a_sgn;
        y_sgn = swap ? a_sgn : b_sgn;
        eff_sub = x_sgn ^ y_sgn;

        x_sig = {|x_mag[FW-2:MAN_W], x_mag[MAN_W-1:0]};
        y_sig = {|y_mag[FW-2:MAN_W], y_mag[MAN_W-1:0]};
        ee_x  = (x_mag[FW-2:MAN_W] == '0) ? 1 : int'(x_mag[FW-2:MAN_W]);
        ee_y  = (y_mag[FW-2:MAN_W] == '0) ? 1 : int'(y_mag[FW-2:MAN_W]);
        diff  = ee_x - ee_y;

        big        = {x_sig, 3'b000};
        small_full = {y_sig, 3'b000};
        if (diff >= W) begin
            algn = '0;
            stk  = |small_full;
        end else begin
            algn = small_full >> diff;
            stk  = |(small_full & ~({W{1'b1}} << diff));
        end
        algn[0] = algn[0] | stk;

        if (eff_sub)
            sum = {1'b0, big} - {1'b0, algn};
        else
            sum = {1'b0, big} + {1'b0, algn};

        lz = W;
        for (int i = 0; i < W; i++)
            if (sum[i]) lz = W - 1 - i;

        if (sum[W]) begin
            nrm   = sum[W:1];
            nstk  = sum[0];
            nexp  = ee_x + 1;
            shamt = 0;
        end else begin
            shamt = (lz < ee_x - 1) ? lz : ee_x - 1;
            nrm   = sum[W-1:0] << shamt;
            nstk  = 1'b0;
            nexp  = ee_x - shamt;
        end

        res_sgn = (sum == '0 && eff_sub) ? (rm == RND_DN) : x_sgn;
        hidden  = nrm[W-1];
        lsb     = nrm[3];
        grd     = nrm[2];
        stk     = (|nrm[1:0]) | nstk;
        case (rm)
            RND_NE:  inc = grd & (stk | lsb);
            RND_UP:  inc = (grd | stk) & !res_sgn;
            RND_DN:  inc = (grd | stk) & res_sgn;
            default: inc = 1'b0;
        endcase
        inexact = grd | stk;

        mant_r = {1'b0, nrm[W-1:3]} + {{SW{1'b0}}, inc};
        efield = hidden ? nexp : 0;
        if (mant_r[SW])
            efield = efield + 1;
        else if (!hidden && mant_r[SW-1])
            efield = 1;

        to_inf = (rm == RND_NE) || (rm == RND_UP && !res_sgn) ||
                 (rm == RND_DN && res_sgn);
        overflow = (efield >= EMAX);
        if (overflow) begin
            inexact = 1'b1;
            y = to_inf ? {res_sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                       : {res_sgn, EXP_W'(EMAX - 1), {MAN_W{1'b1}}};
        end else begin
            y = {res_sgn, EXP_W'(efield), mant_r[MAN_W-1:0]};
        end

        if (a_nan || b_nan || (a_inf && b_inf && (a_sgn ^ b_sgn))) begin
            y = QNAN;
            inexact  = 1'b0;
            overflow = 1'b0;
        end else if (a_inf || b_inf) begin
            y = {a_inf ? a_sgn : b_sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            inexact  = 1'b0;
            overflow = 1'b0;
        end
    end
endmodule

// File: rtl/dirround_fadd.sv
// Top: two adder lanes with registered outputs. Lane 0 serves plain
// operations and the interval lower bound; lane 1 the upper bound.
// Assumes operands are stable at the clock edge where a strobe is high.
module dirround_fadd
    import dirround_fadd_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_mode,
    input  logic                 op_valid,
    input  logic [2:0]           op_code,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic                 ivl_valid,
    input  logic [EXP_W+MAN_W:0] ivl_lo_a,
    input  logic [EXP_W+MAN_W:0] ivl_lo_b,
    input  logic [EXP_W+MAN_W:0] ivl_hi_a,
    input  logic [EXP_W+MAN_W:0] ivl_hi_b,
    output logic                 out_valid,
    output logic                 out_ivl,
    output logic [EXP_W+MAN_W:0] out_lo,
    output logic [EXP_W+MAN_W:0] out_hi,
    output logic [1:0]           out_inexact,
    output logic [1:0]           out_overflow
);
    localparam int FW    = 1 + EXP_W + MAN_W;
    localparam int LANES = 2;

    logic          l0_sub, lfsr_step, rand_mode, fire;
    rnd_e          l0_rm;
    logic [1:0]    rnd_bits;
    logic [FW-1:0] ln_a [LANES], ln_b [LANES], ln_y [LANES], res_q [LANES];
    logic          ln_sub [LANES];
    rnd_e          ln_rm [LANES];
    logic [LANES-1:0] ln_ix, ln_ov, ix_q, ov_q;

    dirround_fadd_ctl ctl_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .op_valid(op_valid), .op_code(op_code), .ivl_valid(ivl_valid),
        .rnd_bits(rnd_bits), .l0_sub(l0_sub), .l0_rm(l0_rm),
        .lfsr_step(lfsr_step), .rand_mode(rand_mode), .fire(fire)
    );

    dirround_fadd_lfsr lfsr_i (
        .clk(clk), .rst_n(rst_n), .step(lfsr_step), .pick(rnd_bits)
    );

    // Route operands and rounding to each lane
    always_comb begin
        ln_a[0]   = ivl_valid ? ivl_lo_a : op_a;
        ln_b[0]   = ivl_valid ? ivl_lo_b : op_b;
        ln_sub[0] = l0_sub;
        ln_rm[0]  = l0_rm;
        ln_a[1]   = ivl_hi_a;
        ln_b[1]   = ivl_hi_b;
        ln_sub[1] = 1'b0;
        ln_rm[1]  = RND_UP;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dirround_fadd_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) core_i (
            .a(ln_a[g]), .b(ln_b[g]), .sub(ln_sub[g]), .rm(ln_rm[g]),
            .y(ln_y[g]), .inexact(ln_ix[g]), .overflow(ln_ov[g])
        );

        // Capture this lane's result when the lane is in use
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g] <= '0;
                ix_q[g]  <= 1'b0;
                ov_q[g]  <= 1'b0;
            end else if (fire) begin
                if (g == 0 || ivl_valid) begin
                    res_q[g] <= ln_y[g];
                    ix_q[g]  <= ln_ix[g];
                    ov_q[g]  <= ln_ov[g];
                end else begin
                    res_q[g] <= '0;
                    ix_q[g]  <= 1'b0;
                    ov_q[g]  <= 1'b0;
                end
            end
        end
    end

    // Result valid and interval markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ivl   <= 1'b0;
        end else begin
            out_valid <= fire;
            out_ivl   <= ivl_valid;
        end
    end

    assign out_lo       = res_q[0];
    assign out_hi       = res_q[1];
    assign out_inexact  = ix_q;
    assign out_overflow = ov_q;
endmodule

// File: rtl/dirround_fadd_chk.sv
// Protocol and flag checks for dirround_fadd, attached by bind.
module dirround_fadd_chk #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [2:0]           op_code,
    input logic                 ivl_valid,
    input logic                 rand_mode,
    input logic [15:0]          lfsr_state,
    input logic                 out_valid,
    input logic                 out_ivl,
    input logic [EXP_W+MAN_W:0] out_lo,
    input logic [EXP_W+MAN_W:0] out_hi,
    input logic [1:0]           out_inexact,
    input logic [1:0]           out_overflow
);
    localparam int FW = 1 + EXP_W + MAN_W;
    logic leg_fire, lo_nan;
    assign leg_fire = op_valid && !ivl_valid && (op_code[2:1] == 2'b00) && rand_mode;
    assign lo_nan   = (&out_lo[FW-2:MAN_W]) && (|out_lo[MAN_W-1:0]);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || ivl_valid) |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid || ivl_valid) |=> !out_valid);
    // R5
    ivl_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_valid |=> (out_ivl && out_valid));
    // R5
    hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ivl) |-> (out_hi == '0 && !out_inexact[1] && !out_overflow[1]));
    // R6
    ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow[0]) |-> out_inexact[0]);
    // R4
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !leg_fire |=> $stable(lfsr_state));
    // R4
    lfsr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leg_fire |=> (lfsr_state != $past(lfsr_state)));
    // R9
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lo_nan) |-> (out_lo[MAN_W-1] && !out_inexact[0] && !out_overflow[0]));
endmodule

bind dirround_fadd dirround_fadd_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .ivl_valid(ivl_valid), .rand_mode(rand_mode), .lfsr_state(lfsr_i.state_q),
    .out_valid(out_valid), .out_ivl(out_ivl), .out_lo(out_lo), .out_hi(out_hi),
    .out_inexact(out_inexact), .out_overflow(out_overflow)
);

// File: tb/dirround_fadd_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module dirround_fadd_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        ivl_valid = 1'b0;
    logic [15:0] ivl_lo_a = '0, ivl_lo_b = '0, ivl_hi_a = '0, ivl_hi_b = '0;
    logic        out_valid, out_ivl;
    logic [15:0] out_lo, out_hi;
    logic [1:0]  out_inexact, out_overflow;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    dirround_fadd dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .op_valid(op_valid), .op_code(op_code), .op_a(op_a), .op_b(op_b),
        .ivl_valid(ivl_valid), .ivl_lo_a(ivl_lo_a), .ivl_lo_b(ivl_lo_b),
        .ivl_hi_a(ivl_hi_a), .ivl_hi_b(ivl_hi_b), .out_valid(out_valid),
        .out_ivl(out_ivl), .out_lo(out_lo), .out_hi(out_hi),
        .out_inexact(out_inexact), .out_overflow(out_overflow)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One operation; sampled at the falling edge after the capturing edge
    task automatic run_op(input logic [2:0] code, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_a = a; op_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_op(input string tag, input logic [2:0] code, input logic [15:0] a,
                             input logic [15:0] b, input logic [15:0] r, input logic ix,
                             input logic ov);
        run_op(code, a, b);
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " result"}, {16'd0, out_lo}, {16'd0, r});
        check({tag, " flags"}, {30'd0, out_inexact[0], out_overflow[0]}, {30'd0, ix, ov});
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_ivl(input string tag, input logic [15:0] la, input logic [15:0] lb,
                           input logic [15:0] ha, input logic [15:0] hb, input logic [15:0] elo,
                           input logic [15:0] ehi, input logic [1:0] eix, input logic [1:0] eov);
        @(negedge clk);
        ivl_valid = 1'b1; ivl_lo_a = la; ivl_lo_b = lb; ivl_hi_a = ha; ivl_hi_b = hb;
        @(negedge clk);
        ivl_valid = 1'b0;
        check({tag, " R5 marks"}, {30'd0, out_valid, out_ivl}, 32'd3);
        check({tag, " R5 bounds"}, {out_lo, out_hi}, {elo, ehi});
        check({tag, " R5 flags"}, {28'd0, out_inexact, out_overflow}, {28'd0, eix, eov});
    endtask

    function automatic logic [15:0] lstep(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle outputs", {out_valid, out_ivl, out_inexact, out_overflow, 12'd0, out_lo},
              32'd0);
        check("R11 hi zero", {16'd0, out_hi}, 32'd0);
        expect_op("R11 nearest default add", 3'b000, 16'h3C00, 16'h1000, 16'h3C00, 1, 0);
        expect_op("R11 nearest default sub", 3'b001, 16'h3C00, 16'h0C00, 16'h3C00, 1, 0);
        @(negedge clk);
        check("R1 no strobe", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_directed;
        expect_op("R1 add-up tie", 3'b010, 16'h3C00, 16'h1000, 16'h3C01, 1, 0);
        expect_op("R1 add-down tie", 3'b011, 16'h3C00, 16'h1000, 16'h3C00, 1, 0);
        expect_op("R1 add-zero tie", 3'b100, 16'h3C00, 16'h1000, 16'h3C00, 1, 0);
        expect_op("R1 sub-up", 3'b101, 16'h3C00, 16'h0C00, 16'h3C00, 1, 0);
        expect_op("R1 sub-down", 3'b110, 16'h3C00, 16'h0C00, 16'h3BFF, 1, 0);
        expect_op("R1 sub-zero", 3'b111, 16'h3C00, 16'h0C00, 16'h3BFF, 1, 0);
        expect_op("R10 exact add", 3'b010, 16'h3C00, 16'h4000, 16'h4200, 0, 0);
        expect_op("R10 exact sub", 3'b110, 16'h4200, 16'h3C00, 16'h4000, 0, 0);
        expect_op("R1 neg add-up", 3'b010, 16'hBC00, 16'h9000, 16'hBC00, 1, 0);
        expect_op("R1 neg add-down", 3'b011, 16'hBC00, 16'h9000, 16'hBC01, 1, 0);
        check("R5 plain op hi lane", {14'd0, out_ivl, out_inexact[1], out_overflow[1], out_hi},
              32'd0);
    endtask

    task automatic t_nearest;
        expect_op("R2 above half", 3'b000, 16'h3C00, 16'h1200, 16'h3C01, 1, 0);
        expect_op("R2 tie to even up", 3'b001, 16'h3C00, 16'h0C00, 16'h3C00, 1, 0);
        expect_op("R2 tie to even stay", 3'b000, 16'h3C00, 16'h1000, 16'h3C00, 1, 0);
    endtask

    task automatic t_legacy;
        set_mode(3'd1);
        expect_op("R3 mode up", 3'b000, 16'h3C00, 16'h1000, 16'h3C01, 1, 0);
        expect_op("R3 directed keeps own", 3'b011, 16'h3C00, 16'h1000, 16'h3C00, 1, 0);
        expect_op("R3 mode persists", 3'b000, 16'h3C00, 16'h1000, 16'h3C01, 1, 0);
        set_mode(3'd2);
        expect_op("R3 mode down sub", 3'b001, 16'h3C00, 16'h0C00, 16'h3BFF, 1, 0);
        expect_op("R3 mode down neg", 3'b000, 16'hBC00, 16'h9000, 16'hBC01, 1, 0);
        set_mode(3'd3);
        expect_op("R3 mode zero neg", 3'b000, 16'hBC00, 16'h9000, 16'hBC00, 1, 0);
        set_mode(3'd0);
        // write and operation in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 3'd1;
        op_valid = 1'b1; op_code = 3'b000; op_a = 16'h3C00; op_b = 16'h1000;
        @(negedge clk);
        cfg_we = 1'b0; op_valid = 1'b0;
        check("R3 same-cycle write uses old", {16'd0, out_lo}, 32'h3C00);
        expect_op("R3 write effective next", 3'b000, 16'h3C00, 16'h1000, 16'h3C01, 1, 0);
        set_mode(3'd0);
    endtask

    task automatic t_overflow;
        expect_op("R6 pos up", 3'b010, 16'h7BFF, 16'h7BFF, 16'h7C00, 1, 1);
        expect_op("R6 pos down", 3'b011, 16'h7BFF, 16'h7BFF, 16'h7BFF, 1, 1);
        expect_op("R6 pos zero", 3'b100, 16'h7BFF, 16'h7BFF, 16'h7BFF, 1, 1);
        expect_op("R6 pos nearest", 3'b000, 16'h7BFF, 16'h7BFF, 16'h7C00, 1, 1);
        expect_op("R6 neg up", 3'b010, 16'hFBFF, 16'hFBFF, 16'hFBFF, 1, 1);
        expect_op("R6 neg down", 3'b011, 16'hFBFF, 16'hFBFF, 16'hFC00, 1, 1);
        expect_op("R6 round-up carry", 3'b010, 16'h7BFF, 16'h3C00, 16'h7C00, 1, 1);
        expect_op("R6 no overflow down", 3'b011, 16'h7BFF, 16'h3C00, 16'h7BFF, 1, 0);
    endtask

    task automatic t_zero;
        expect_op("R7 sub-down", 3'b110, 16'h3C00, 16'h3C00, 16'h8000, 0, 0);
        expect_op("R7 sub-up", 3'b101, 16'h3C00, 16'h3C00, 16'h0000, 0, 0);
        expect_op("R7 sub-zero", 3'b111, 16'h3C00, 16'h3C00, 16'h0000, 0, 0);
        expect_op("R7 add-down opp", 3'b011, 16'h3C00, 16'hBC00, 16'h8000, 0, 0);
        expect_op("R7 neg zeros", 3'b010, 16'h8000, 16'h8000, 16'h8000, 0, 0);
        expect_op("R7 pos zeros down", 3'b011, 16'h0000, 16'h0000, 16'h0000, 0, 0);
    endtask

    task automatic t_subnormal;
        expect_op("R8 tiny sum", 3'b100, 16'h0001, 16'h0001, 16'h0002, 0, 0);
        expect_op("R8 into normal", 3'b010, 16'h03FF, 16'h0001, 16'h0400, 0, 0);
        expect_op("R8 out of normal", 3'b110, 16'h0400, 16'h0001, 16'h03FF, 0, 0);
        expect_op("R8 neg subnormal", 3'b101, 16'h0001, 16'h0002, 16'h8001, 0, 0);
        expect_op("R8 far sticky up", 3'b010, 16'h3C00, 16'h0001, 16'h3C01, 1, 0);
        expect_op("R8 far sticky down", 3'b011, 16'h3C00, 16'h0001, 16'h3C00, 1, 0);
    endtask

    task automatic t_special;
        expect_op("R9 nan in", 3'b010, 16'h7E00, 16'h3C00, 16'h7E00, 0, 0);
        expect_op("R9 neg nan in", 3'b100, 16'hFE01, 16'h3C00, 16'h7E00, 0, 0);
        expect_op("R9 inf minus inf", 3'b111, 16'h7C00, 16'h7C00, 16'h7E00, 0, 0);
        expect_op("R9 inf plus one", 3'b011, 16'h7C00, 16'h3C00, 16'h7C00, 0, 0);
        expect_op("R9 neg inf", 3'b010, 16'h3C00, 16'hFC00, 16'hFC00, 0, 0);
        expect_op("R9 sub inf", 3'b101, 16'h3C00, 16'h7C00, 16'hFC00, 0, 0);
    endtask

    task automatic t_interval;
        run_ivl("ivl tie", 16'h3C00, 16'h1000, 16'h3C00, 16'h1000, 16'h3C00, 16'h3C01, 2'b11, 2'b00);
        run_ivl("ivl mixed", 16'hBC00, 16'h9000, 16'h3C00, 16'h1000, 16'hBC01, 16'h3C01, 2'b11, 2'b00);
        run_ivl("ivl overflow", 16'h7BFF, 16'h7BFF, 16'h7BFF, 16'h7BFF, 16'h7BFF, 16'h7C00, 2'b11, 2'b11);
        run_ivl("ivl exact", 16'h3C00, 16'h4000, 16'h3C00, 16'h4000, 16'h4200, 16'h4200, 2'b00, 2'b00);
    endtask

    task automatic t_random;
        logic [15:0] m;
        logic [15:0] exp_r;
        m = 16'hACE1;
        set_mode(3'd4);
        for (int i = 0; i < 24; i++) begin
            if (i % 3 == 2)
                expect_op("R4 directed in random", 3'b010, 16'h3C00, 16'h1000, 16'h3C01, 1, 0);
            if (i == 10) begin
                @(negedge clk);
                op_valid = 1'b1; op_code = 3'b000; op_a = 16'h7BFF; op_b = 16'h7BFF;
                ivl_valid = 1'b1; ivl_lo_a = 16'h3C00; ivl_lo_b = 16'h1000;
                ivl_hi_a = 16'h3C00; ivl_hi_b = 16'h1000;
                @(negedge clk);
                op_valid = 1'b0; ivl_valid = 1'b0;
                check("R5 priority over op", {out_lo, out_hi}, {16'h3C00, 16'h3C01});
            end
            if (i % 2 == 0) begin
                case (m[1:0])
                    2'd1:    exp_r = 16'h3C01;
                    default: exp_r = 16'h3C00;
                endcase
                expect_op("R4 random pos tie", 3'b000, 16'h3C00, 16'h1000, exp_r, 1, 0);
            end else begin
                case (m[1:0])
                    2'd2:    exp_r = 16'hBC01;
                    default: exp_r = 16'hBC00;
                endcase
                expect_op("R4 random neg tie", 3'b000, 16'hBC00, 16'h9000, exp_r, 1, 0);
            end
            m = lstep(m);
        end
        set_mode(3'd0);
    endtask

    initial begin
        t_reset();
        t_directed();
        t_nearest();
        t_legacy();
        t_overflow();
        t_zero();
        t_subnormal();
        t_special();
        t_interval();
        t_random();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule